// File: doc/BRIEF.md
# SPI Controller Core with Status Sequencing

This block is a serial peripheral interface controller that works either as the bus master or as a slave. Software reaches it through three byte-wide registers on a small register port: control, status and data. In master mode a data write launches an eight-bit full-duplex exchange, with the serial clock generated by dividing the system clock. In slave mode the same write only preloads the byte that the remote master will clock out.

The transmit side has one stage: the shift register itself. The receive side has two: a finished byte moves from the shift register into a read buffer, and software reads that buffer. The status register reports a transfer-complete flag, an overrun flag and a mode-fault flag. Each flag clears only through a two-step access sequence, so software cannot drop a flag it has not seen. A master that finds its slave-select input pulled active gives up the bus at once, by falling back to slave mode with outputs disabled.

Top module: `spi_core`

## Requirements
- R1: Register select 0 is control (bit 0 enable, bit 1 master, other bits read 0), select 1 is status (bit 7 transfer complete, bit 6 overrun, bit 4 mode fault, every other bit reads 0), and select 2 is data. After reset, control and status both read 0x00.
- R2: A data write while enabled, in master mode and idle starts an exchange of 8 bits, MSB first. The serial clock idles low and has a period of 2*HALF_DIV system clocks. MISO is sampled on each rising edge and MOSI changes on each falling edge. The complete flag becomes visible 16*HALF_DIV cycles after the write edge.
- R3: A data write in slave mode only loads the transmit byte. No serial clock is driven and no flag changes.
- R4: A slave that is enabled with ssN low samples mosiIn on rising sckIn, drives misoOut from the MSB of its byte, and shifts on falling sckIn. The byte is complete after the eighth falling edge. While ssN is high, clock edges are ignored.
- R5: A completed byte sets the transfer-complete flag in both modes. A data read returns the read buffer, not the live shift register.
- R6: The transfer-complete flag clears only when a status read that saw it set is followed by a data read or write. A data access with no such status read leaves the flag set.
- R7: If a byte completes while the complete flag is still set, the overrun flag is set, the new byte is discarded, and the buffered byte is kept. Overrun clears through the same sequence as R6.
- R8: If the block is enabled as master and ssN goes low, the mode-fault flag is set, the enable and master bits clear, a running transfer stops, and the master outputs are released.
- R9: Mode fault clears only when a status read that saw it set is followed by a control write.
- R10: sckOe and mosiOe are high only when the block is enabled as master. misoOe is high only when the block is enabled as slave with ssN low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regSel | input | 2 | Register select: 0 control, 1 status, 2 data |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data for the selected register |
| sckOut | output | 1 | Serial clock driven in master mode |
| sckOe | output | 1 | Serial clock output enable |
| mosiOut | output | 1 | Master data out |
| mosiOe | output | 1 | Master data output enable |
| misoIn | input | 1 | Master data in |
| sckIn | input | 1 | Serial clock seen in slave mode |
| mosiIn | input | 1 | Slave data in |
| misoOut | output | 1 | Slave data out |
| misoOe | output | 1 | Slave data output enable |
| ssN | input | 1 | Active-low slave select |

## Verification
The assertions check on every cycle that a flag falls only after its complete two-step clear sequence, and that overrun rises only while an unread completion is still pending. They also check that a mode fault leaves the block disabled and out of master mode, that the serial clock rests low whenever no master transfer is running, and that the master and slave pin enables never overlap. Other behaviour only the bench scenarios can show: the bit order and edge timing of a real exchange, the byte kept by the buffer on overrun, a slave that ignores a data write and ignores edges while deselected, and a transfer cut off by a fault.

// File: rtl/spi_core_pkg.sv
package spi_core_pkg;
  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_STAT = 2'd1;
  localparam logic [1:0] SEL_DATA = 2'd2;

  // strobes from control to datapath
  typedef struct packed {
    logic loadTx;     // preload shift register, no clocking
    logic startXfer;  // preload and begin master exchange
    logic abort;      // stop master exchange (mode fault)
    logic captureRx;  // move finished byte into read buffer
    logic slaveEn;    // slave shifting allowed
  } dpStrobe_t;
endpackage

// File: rtl/spi_dpath.sv
module spi_dpath
  import spi_core_pkg::*;
#(
  parameter int WIDTH    = 8,
  parameter int HALF_DIV = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strb,
  input  logic [WIDTH-1:0] txData,
  output logic [WIDTH-1:0] rxBuf,
  output logic             doneEvt,
  output logic             busy,
  output logic             sckOut,
  output logic             mosiOut,
  input  logic             misoIn,
  input  logic             sckIn,
  input  logic             mosiIn,
  output logic             misoOut,
  input  logic             ssN
);
  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int BIT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(WIDTH - 1);

  logic [WIDTH-1:0] shiftReg;
  logic [WIDTH-1:0] rxByte;
  logic [DIV_W-1:0] divCnt;
  logic [BIT_W-1:0] bitCnt;
  logic             sckReg;
  logic             sckPrev;
  logic             sampleBit;

  logic slvActive, slvRise, slvFall;
  logic mstTick, mstLead, mstTrail;
  logic leadEdge, trailEdge, lastBit;

  assign slvActive = strb.slaveEn & ~ssN;
  assign slvRise   = slvActive & sckIn & ~sckPrev;
  assign slvFall   = slvActive & ~sckIn & sckPrev;
  assign mstTick   = busy & (divCnt == DIV_LAST);
  assign mstLead   = mstTick & ~sckReg;
  assign mstTrail  = mstTick & sckReg;
  assign leadEdge  = mstLead | slvRise;
  assign trailEdge = mstTrail | slvFall;
  assign lastBit   = (bitCnt == BIT_LAST);
  assign doneEvt   = trailEdge & lastBit;
  assign rxByte    = {shiftReg[WIDTH-2:0], sampleBit};

  assign sckOut  = sckReg;
  assign mosiOut = shiftReg[WIDTH-1];
  assign misoOut = shiftReg[WIDTH-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '0;
      divCnt    <= '0;
      bitCnt    <= '0;
      sckReg    <= 1'b0;
      sckPrev   <= 1'b0;
      sampleBit <= 1'b0;
      busy      <= 1'b0;
    end else begin
      sckPrev <= sckIn;
      if (strb.abort) begin
        busy   <= 1'b0;
        sckReg <= 1'b0;
        divCnt <= '0;
        bitCnt <= '0;
      end else if (strb.startXfer) begin
        shiftReg <= txData;
        busy     <= 1'b1;
        sckReg   <= 1'b0;
        divCnt   <= '0;
        bitCnt   <= '0;
      end else if (strb.loadTx) begin
        shiftReg <= txData;
        bitCnt   <= '0;
      end else begin
        if (busy) begin
          divCnt <= mstTick ? '0 : divCnt + DIV_W'(1);
          if (mstTick) sckReg <= ~sckReg;
        end
        if (leadEdge) sampleBit <= busy ? misoIn : mosiIn;
        if (trailEdge) begin
          shiftReg <= rxByte;
          bitCnt   <= lastBit ? '0 : bitCnt + BIT_W'(1);
          if (lastBit) busy <= 1'b0;
        end else if (strb.slaveEn && ssN) begin
          bitCnt <= '0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rxBuf <= '0;
    else if (strb.captureRx) rxBuf <= rxByte;
  end

  // serial clock rests low whenever the master is not running
  assert_sck_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !sckOut);

  // a deselected slave never finishes a byte
  assert_slave_gated_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.slaveEn && ssN && !busy) |-> !doneEvt);
endmodule

// File: rtl/spi_ctrl.sv
module spi_ctrl
  import spi_core_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       regSel,
  input  logic             regWr,
  input  logic             regRd,
  input  logic [WIDTH-1:0] regWdata,
  output logic [WIDTH-1:0] regRdata,
  input  logic             doneEvt,
  input  logic             busy,
  input  logic             ssN,
  input  logic [WIDTH-1:0] rxBuf,
  output dpStrobe_t        strb,
  output logic             cfgEnable,
  output logic             cfgMaster
);
  logic xferDone, overrun, modeFault;
  logic doneArmed, faultArmed;
  logic ctrlWr, statusRd, dataWr, dataAcc;
  logic clearNow, keepOld, faultNow;
  logic [WIDTH-1:0] statusByte, ctrlByte;

  assign ctrlWr   = regWr & (regSel == SEL_CTRL);
  assign statusRd = regRd & (regSel == SEL_STAT);
  assign dataWr   = regWr & (regSel == SEL_DATA);
  assign dataAcc  = (regWr | regRd) & (regSel == SEL_DATA);
  assign clearNow = dataAcc & doneArmed;
  assign keepOld  = xferDone & ~clearNow;
  assign faultNow = cfgEnable & cfgMaster & ~ssN;

  assign statusByte = WIDTH'({xferDone, overrun, 1'b0, modeFault, 4'b0000});
  assign ctrlByte   = WIDTH'({cfgMaster, cfgEnable});

  always_comb begin
    case (regSel)
      SEL_CTRL: regRdata = ctrlByte;
      SEL_STAT: regRdata = statusByte;
      SEL_DATA: regRdata = rxBuf;
      default:  regRdata = '0;
    endcase
  end

  always_comb begin
    strb.startXfer = dataWr & cfgEnable & cfgMaster & ~busy & ~faultNow;
    strb.loadTx    = dataWr & ~(cfgEnable & cfgMaster);
    strb.abort     = faultNow;
    strb.captureRx = doneEvt & ~keepOld;
    strb.slaveEn   = cfgEnable & ~cfgMaster;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgEnable  <= 1'b0;
      cfgMaster  <= 1'b0;
      xferDone   <= 1'b0;
      overrun    <= 1'b0;
      modeFault  <= 1'b0;
      doneArmed  <= 1'b0;
      faultArmed <= 1'b0;
    end else begin
      if (faultNow) begin
        cfgEnable <= 1'b0;
        cfgMaster <= 1'b0;
      end else if (ctrlWr) begin
        cfgEnable <= regWdata[0];
        cfgMaster <= regWdata[1];
      end

      if (faultNow) modeFault <= 1'b1;
      else if (ctrlWr && faultArmed) modeFault <= 1'b0;

      if (ctrlWr) faultArmed <= 1'b0;
      else if (statusRd && modeFault) faultArmed <= 1'b1;

      if (doneEvt && !keepOld) xferDone <= 1'b1;
      else if (clearNow) xferDone <= 1'b0;

      if (doneEvt && keepOld) overrun <= 1'b1;
      else if (clearNow) overrun <= 1'b0;

      if (dataAcc) doneArmed <= 1'b0;
      else if (statusRd && xferDone) doneArmed <= 1'b1;
    end
  end

  assert_done_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(xferDone) |-> $past(dataAcc && doneArmed));

  assert_overrun_origin_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> $past(xferDone));

  assert_fault_drop_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(modeFault) |-> (!cfgEnable && !cfgMaster));

  assert_fault_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(modeFault) |-> $past(ctrlWr && faultArmed));
endmodule

// File: rtl/spi_core.sv
module spi_core
  import spi_core_pkg::*;
#(
  parameter int WIDTH    = 8,
  parameter int HALF_DIV = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       regSel,
  input  logic             regWr,
  input  logic             regRd,
  input  logic [WIDTH-1:0] regWdata,
  output logic [WIDTH-1:0] regRdata,
  output logic             sckOut,
  output logic             sckOe,
  output logic             mosiOut,
  output logic             mosiOe,
  input  logic             misoIn,
  input  logic             sckIn,
  input  logic             mosiIn,
  output logic             misoOut,
  output logic             misoOe,
  input  logic             ssN
);
  dpStrobe_t        strb;
  logic [WIDTH-1:0] rxBuf;
  logic             doneEvt, busy, cfgEnable, cfgMaster;

  spi_ctrl #(.WIDTH(WIDTH)) uCtrl (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .regRdata(regRdata), .doneEvt(doneEvt), .busy(busy),
    .ssN(ssN), .rxBuf(rxBuf), .strb(strb), .cfgEnable(cfgEnable),
    .cfgMaster(cfgMaster)
  );

  spi_dpath #(.WIDTH(WIDTH), .HALF_DIV(HALF_DIV)) uDpath (
    .clk(clk), .rstN(rstN), .strb(strb), .txData(regWdata), .rxBuf(rxBuf),
    .doneEvt(doneEvt), .busy(busy), .sckOut(sckOut), .mosiOut(mosiOut),
    .misoIn(misoIn), .sckIn(sckIn), .mosiIn(mosiIn), .misoOut(misoOut),
    .ssN(ssN)
  );

  assign sckOe  = cfgEnable & cfgMaster;
  assign mosiOe = cfgEnable & cfgMaster;
  assign misoOe = strb.slaveEn & ~ssN;

  assert_pin_exclusive_R10: assert property (@(posedge clk) disable iff (!rstN)
    misoOe |-> !sckOe);
endmodule

// File: tb/sim_spi_core.sv
`timescale 1ns/1ps
module sim_spi_core;
  localparam int HALF = 2;
  localparam logic [1:0] S_CTRL = 2'd0, S_STAT = 2'd1, S_DATA = 2'd2;
  // {byte written by software, byte returned by remote slave}
  localparam logic [15:0] VEC [4] = '{16'hA53C, 16'h00FF, 16'hFF00, 16'h817E};

  logic clk = 0, rstN = 0;
  logic [1:0] regSel = 0;
  logic regWr = 0, regRd = 0;
  logic [7:0] regWdata = 0, regRdata;
  logic sckOut, sckOe, mosiOut, mosiOe, misoOut, misoOe;
  logic misoIn, sckIn = 0, mosiIn = 0, ssN = 1;
  logic [7:0] peerShift = 0, peerRx = 0;
  int nRun = 0, nFail = 0, cycles = 0;

  always #4 clk = ~clk;

  spi_core #(.WIDTH(8), .HALF_DIV(HALF)) u0 (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .regRdata(regRdata), .sckOut(sckOut), .sckOe(sckOe),
    .mosiOut(mosiOut), .mosiOe(mosiOe), .misoIn(misoIn), .sckIn(sckIn),
    .mosiIn(mosiIn), .misoOut(misoOut), .misoOe(misoOe), .ssN(ssN)
  );

  // remote slave model for master exchanges
  always_comb misoIn = peerShift[7];
  always @(negedge sckOut) peerShift = {peerShift[6:0], 1'b0};
  always @(posedge sckOut) peerRx = {peerRx[6:0], mosiOut};

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      nFail++;
      $display("FAIL watchdog: run did not finish");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk); regSel = sel; regWdata = d; regWr = 1;
    @(negedge clk); regWr = 0;
  endtask

  task automatic regRead(input logic [1:0] sel, output logic [7:0] d);
    @(negedge clk); regSel = sel; regRd = 1; #1 d = regRdata;
    @(negedge clk); regRd = 0;
  endtask

  task automatic masterXfer(input logic [7:0] tx, input logic [7:0] peer);
    peerShift = peer;
    regWrite(S_DATA, tx);
    repeat (16*HALF + 4) @(posedge clk);
  endtask

  task automatic slaveBit(input logic b, output logic got);
    mosiIn = b; repeat (3) @(negedge clk);
    sckIn = 1;  repeat (3) @(negedge clk);
    got = misoOut;
    sckIn = 0;  repeat (3) @(negedge clk);
  endtask

  initial begin
    logic [7:0] v, got;
    logic bitv;
    repeat (3) @(negedge clk);
    rstN = 1;
    regRead(S_CTRL, v); check("R1 control after reset", v, 8'h00);
    regRead(S_STAT, v); check("R1 status after reset", v, 8'h00);

    regWrite(S_CTRL, 8'h03);
    check("R10 sckOe in master", {7'b0, sckOe}, 8'h01);
    check("R10 misoOe in master", {7'b0, misoOe}, 8'h00);

    // timing of completion
    peerShift = 8'h5A;
    regWrite(S_DATA, 8'hC6);
    repeat (16*HALF - 2) @(posedge clk);
    regRead(S_STAT, v); check("R2 not done one cycle early", v, 8'h00);
    regRead(S_STAT, v); check("R2 done on time", v, 8'h80);
    check("R2 sck idle low", {7'b0, sckOut}, 8'h00);
    regRead(S_DATA, v); check("R5 first byte", v, 8'h5A);
    check("R2 peer got tx", peerRx, 8'hC6);

    // vector table of master exchanges
    for (int i = 0; i < 4; i++) begin
      masterXfer(VEC[i][15:8], VEC[i][7:0]);
      check("R2 mosi byte MSB first", peerRx, VEC[i][15:8]);
      regRead(S_STAT, v); check("R5 complete flag", v, 8'h80);
      regRead(S_DATA, v); check("R5 read buffer", v, VEC[i][7:0]);
      regRead(S_STAT, v); check("R6 cleared after sequence", v, 8'h00);
    end

    // R6: data access without status read does not clear
    masterXfer(8'h11, 8'h44);
    regRead(S_DATA, v); check("R6 data early", v, 8'h44);
    regRead(S_STAT, v); check("R6 flag kept", v, 8'h80);
    regRead(S_DATA, v);
    regRead(S_STAT, v); check("R6 flag cleared", v, 8'h00);

    // R7: overrun
    masterXfer(8'h22, 8'h11);
    masterXfer(8'h33, 8'h99);
    regRead(S_STAT, v); check("R7 overrun set", v, 8'hC0);
    regRead(S_DATA, v); check("R7 old byte kept", v, 8'h11);
    regRead(S_STAT, v); check("R7 overrun cleared", v, 8'h00);

    // R8: fault mid transfer
    peerShift = 8'h00;
    regWrite(S_DATA, 8'hF0);
    repeat (5) @(negedge clk);
    ssN = 0; repeat (3) @(negedge clk); ssN = 1;
    repeat (40) @(negedge clk);
    check("R8 outputs released", {6'b0, sckOe, sckOut}, 8'h00);
    regRead(S_CTRL, v); check("R8 enable and master cleared", v, 8'h00);
    regWrite(S_CTRL, 8'h00);
    regRead(S_STAT, v); check("R9 fault survives plain control write", v, 8'h10);
    regWrite(S_CTRL, 8'h00);
    regRead(S_STAT, v); check("R9 fault cleared", v, 8'h00);

    // slave mode
    regWrite(S_CTRL, 8'h01);
    check("R10 misoOe deselected", {7'b0, misoOe}, 8'h00);
    regWrite(S_DATA, 8'hC3);
    repeat (40) @(negedge clk);
    check("R3 no master clock", {6'b0, sckOe, sckOut}, 8'h00);
    regRead(S_STAT, v); check("R3 no flag", v, 8'h00);
    ssN = 0; @(negedge clk);
    check("R10 misoOe selected", {7'b0, misoOe}, 8'h01);
    got = 0;
    for (int b = 7; b >= 0; b--) begin
      slaveBit(v_bit(8'h5A, b), bitv);
      got = {got[6:0], bitv};
    end
    check("R4 slave miso byte", got, 8'hC3);
    regRead(S_STAT, v); check("R5 slave complete", v, 8'h80);
    regRead(S_DATA, v); check("R4 slave received", v, 8'h5A);
    regRead(S_STAT, v); check("R6 slave cleared", v, 8'h00);
    ssN = 1;
    for (int b = 0; b < 8; b++) slaveBit(1'b1, bitv);
    regRead(S_STAT, v); check("R4 deselected edges ignored", v, 8'h00);

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  function automatic logic v_bit(input logic [7:0] d, input int idx);
    return d[idx];
  endfunction
endmodule